// File: doc/BRIEF.md
# Parallel ATA Strobe Timing Generator

This block generates the active-low read and write strobes of a parallel ATA channel. Two devices share the channel, and each has its own 32-bit timing word. A request names the device, the direction and the kind of access: a data transfer (PIO or multiword DMA) or a task-file register access. On a request that starts from rest, the block captures the selected device's word. It waits out the setup delay for that access kind. It then holds the chosen strobe low for the active count and high for the inactive count. Acknowledge marks the end of the access.

A requester holds `reqValid` high until it sees `reqAck`. If `reqValid` is still high in the idle cycle that follows the acknowledge, that request continues a burst. The setup delay is skipped, and the timing fields captured at the start of the burst are reused. Direction and access kind are taken again for every access. Four mode flags from the top nibble of the captured word are presented on `modeFlags` for neighbouring logic. The flags have no effect inside this block.

Top module: `pataStrobeTimer`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle with both strobes high, `reqAck` low and `modeFlags` zero. This includes a reset that arrives in the middle of an access. The first request after a reset always pays its setup delay.
- R2: In a data access (`reqCmd`=0), the strobe is low for word[7:4]+1 cycles. It then goes high for word[3:0]+1 cycles.
- R3: In a task-file access (`reqCmd`=1), the strobe is low for word[15:12]+1 cycles. It then goes high for word[11:8]+1 cycles.
- R4: A request that starts from rest is sampled in an idle cycle. Both strobes then stay high for S+1 cycles before the strobe falls. S is word[21:19] for a data access and word[24:22] for a task-file access.
- R5: `reqWrite`=1 drives only `wrStrobeN` low, and `reqWrite`=0 drives only `rdStrobeN` low. The two strobes are never low together.
- R6: `reqDev`=0 selects `timingWord0` and `reqDev`=1 selects `timingWord1`. The selection is made when the word is captured.
- R7: `reqAck` is high for exactly one cycle, which is the last cycle of the inactive count. Requests are only accepted in idle.
- R8: A request that is high in the idle cycle right after an acknowledge continues the burst. The strobe falls after that single high idle cycle, and the setup delay is skipped. Direction and access kind come from the new request. The active and inactive counts come from the word captured at the start of the burst, whatever the device select says.
- R9: One idle cycle with `reqValid` low ends a burst. The next request captures a fresh word and pays its setup delay.
- R10: Changes on `timingWord0` or `timingWord1` have no effect during an access or a burst. This holds for changes during the setup, active or inactive count.
- R11: `modeFlags` equals word[31:28] of the captured word. Its bits are [3]=FIFO enable, [2]=bus-master PIO, [1]=DMA enable and [0]=Ultra DMA enable. It holds until the next fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Access request, held until acknowledged |
| reqWrite | input | 1 | 1 = write strobe, 0 = read strobe |
| reqCmd | input | 1 | 1 = task-file register access, 0 = data transfer |
| reqDev | input | 1 | Device select for timing word capture |
| timingWord0 | input | 32 | Timing word of device 0 |
| timingWord1 | input | 32 | Timing word of device 1 |
| reqAck | output | 1 | One-cycle pulse in the final inactive cycle |
| rdStrobeN | output | 1 | Active-low read strobe |
| wrStrobeN | output | 1 | Active-low write strobe |
| modeFlags | output | 4 | Mode flags from the captured word |

## Verification
The bench sweeps every value of the 4-bit active and inactive fields and all setup values. It runs each one with both devices, both directions and both access kinds. This catches swapped data and task-file fields, a missing +1, a wrong device index and a strobe on the wrong pin. Bursts are checked for a strobe that falls after one idle cycle. A design that reapplied the setup delay, or took a new word inside a burst, would show a longer lead-in or different counts. Timing words are changed in the middle of an access, and a reset is applied while a strobe is low. A design that samples the word outside idle, or leaves burst state behind after reset, shows altered counts or a missing setup delay.

// File: rtl/pataTimingPkg.sv
package pataTimingPkg;

  localparam int WORD_W         = 32;
  localparam int PULSE_W        = 4;
  localparam int SETUP_W        = 3;
  localparam int FLAG_W         = 4;

  localparam int DATA_INACT_LSB = 0;
  localparam int DATA_ACT_LSB   = 4;
  localparam int CMD_INACT_LSB  = 8;
  localparam int CMD_ACT_LSB    = 12;
  localparam int DATA_SETUP_LSB = 19;
  localparam int CMD_SETUP_LSB  = 22;
  localparam int FLAG_LSB       = 28;

  localparam int CNT_W = (PULSE_W > SETUP_W) ? PULSE_W : SETUP_W;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef struct packed {
    logic captureWord;
    logic captureAccess;
    logic loadSetup;
    logic loadActive;
    logic loadInactive;
    logic countDown;
  } dpCtrl_t;

  typedef struct packed {
    logic [FLAG_W-1:0]  flags;
    logic [SETUP_W-1:0] cmdSetup;
    logic [SETUP_W-1:0] dataSetup;
    logic [PULSE_W-1:0] cmdAct;
    logic [PULSE_W-1:0] cmdInact;
    logic [PULSE_W-1:0] dataAct;
    logic [PULSE_W-1:0] dataInact;
  } timingFields_t;

  function automatic timingFields_t decodeWord(input logic [WORD_W-1:0] w);
    timingFields_t f;
    f.dataInact = w[DATA_INACT_LSB +: PULSE_W];
    f.dataAct   = w[DATA_ACT_LSB   +: PULSE_W];
    f.cmdInact  = w[CMD_INACT_LSB  +: PULSE_W];
    f.cmdAct    = w[CMD_ACT_LSB    +: PULSE_W];
    f.dataSetup = w[DATA_SETUP_LSB +: SETUP_W];
    f.cmdSetup  = w[CMD_SETUP_LSB  +: SETUP_W];
    f.flags     = w[FLAG_LSB       +: FLAG_W];
    return f;
  endfunction

endpackage

// File: rtl/pataTimingDatapath.sv
module pataTimingDatapath
  import pataTimingPkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpCtrl_t                 ctrl,
  input  logic [WORD_W-1:0]       wordBank [NUM_DEV],
  input  logic [DEV_W-1:0]        reqDev,
  input  logic                    reqWrite,
  input  logic                    reqCmd,
  output logic                    cntZero,
  output logic                    isWrite,
  output logic [FLAG_W-1:0]       modeFlags
);

  timingFields_t selFields;
  timingFields_t heldFields;
  logic          isCmdQ;
  logic          isWriteQ;
  logic [CNT_W-1:0] cnt;
  logic          activeUsesCmd;
  logic [CNT_W-1:0] setupVal;
  logic [CNT_W-1:0] activeVal;
  logic [CNT_W-1:0] inactVal;

  always_comb begin
    selFields = decodeWord(wordBank[reqDev]);
  end

  assign setupVal      = reqCmd ? CNT_W'(selFields.cmdSetup) : CNT_W'(selFields.dataSetup);
  // in a burst the active count is loaded in the same edge that takes the new access kind
  assign activeUsesCmd = ctrl.captureAccess ? reqCmd : isCmdQ;
  assign activeVal     = activeUsesCmd ? CNT_W'(heldFields.cmdAct) : CNT_W'(heldFields.dataAct);
  assign inactVal      = isCmdQ ? CNT_W'(heldFields.cmdInact) : CNT_W'(heldFields.dataInact);

  always_ff @(posedge clk) begin
    if (rst) begin
      heldFields <= '0;
      isCmdQ     <= 1'b0;
      isWriteQ   <= 1'b0;
      cnt        <= '0;
    end else begin
      if (ctrl.captureWord) begin
        heldFields <= selFields;
      end
      if (ctrl.captureAccess) begin
        isCmdQ   <= reqCmd;
        isWriteQ <= reqWrite;
      end
      if (ctrl.loadSetup) begin
        cnt <= setupVal;
      end else if (ctrl.loadActive) begin
        cnt <= activeVal;
      end else if (ctrl.loadInactive) begin
        cnt <= inactVal;
      end else if (ctrl.countDown) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign cntZero   = (cnt == '0);
  assign isWrite   = isWriteQ;
  assign modeFlags = heldFields.flags;

endmodule

// File: rtl/pataStrobeCtrl.sv
module pataStrobeCtrl
  import pataTimingPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    cntZero,
  output dpCtrl_t ctrl,
  output phase_e  phase,
  output logic    reqAck
);

  phase_e phaseNext;
  logic   burstArm;
  logic   burstArmNext;

  always_comb begin
    ctrl         = '0;
    phaseNext    = phase;
    burstArmNext = burstArm;
    unique case (phase)
      PH_IDLE: begin
        burstArmNext = 1'b0;
        if (reqValid) begin
          ctrl.captureAccess = 1'b1;
          if (burstArm) begin
            ctrl.loadActive = 1'b1;
            phaseNext       = PH_ACTIVE;
          end else begin
            ctrl.captureWord = 1'b1;
            ctrl.loadSetup   = 1'b1;
            phaseNext        = PH_SETUP;
          end
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          ctrl.loadActive = 1'b1;
          phaseNext       = PH_ACTIVE;
        end else begin
          ctrl.countDown = 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (cntZero) begin
          ctrl.loadInactive = 1'b1;
          phaseNext         = PH_RECOVER;
        end else begin
          ctrl.countDown = 1'b1;
        end
      end
      PH_RECOVER: begin
        if (cntZero) begin
          burstArmNext = 1'b1;
          phaseNext    = PH_IDLE;
        end else begin
          ctrl.countDown = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      burstArm <= 1'b0;
    end else begin
      phase    <= phaseNext;
      burstArm <= burstArmNext;
    end
  end

  assign reqAck = (phase == PH_RECOVER) && cntZero;

endmodule

// File: rtl/pataStrobeTimer.sv
module pataStrobeTimer
  import pataTimingPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqCmd,
  input  logic              reqDev,
  input  logic [WORD_W-1:0] timingWord0,
  input  logic [WORD_W-1:0] timingWord1,
  output logic              reqAck,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic [FLAG_W-1:0] modeFlags
);

  localparam int NUM_DEV = 2;

  dpCtrl_t           ctrl;
  phase_e            phase;
  logic              cntZero;
  logic              isWrite;
  logic [WORD_W-1:0] wordBank [NUM_DEV];

  assign wordBank[0] = timingWord0;
  assign wordBank[1] = timingWord1;

  pataStrobeCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .cntZero  (cntZero),
    .ctrl     (ctrl),
    .phase    (phase),
    .reqAck   (reqAck)
  );

  pataTimingDatapath #(.NUM_DEV(NUM_DEV)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .wordBank  (wordBank),
    .reqDev    (reqDev),
    .reqWrite  (reqWrite),
    .reqCmd    (reqCmd),
    .cntZero   (cntZero),
    .isWrite   (isWrite),
    .modeFlags (modeFlags)
  );

  assign rdStrobeN = !((phase == PH_ACTIVE) && !isWrite);
  assign wrStrobeN = !((phase == PH_ACTIVE) &&  isWrite);

endmodule

// File: rtl/pataStrobeTimerChecker.sv
module pataStrobeTimerChecker
  import pataTimingPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reqAck,
  input logic              rdStrobeN,
  input logic              wrStrobeN,
  input logic [FLAG_W-1:0] modeFlags
);

  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  // R1: one edge after a reset edge the outputs are quiet
  always_ff @(posedge clk) begin
    if (rstSeen && rst) begin
      assert_reset_quiet_R1: assert (rdStrobeN && wrStrobeN && !reqAck && modeFlags == '0)
        else $error("reset left outputs active");
    end
  end

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !(!rdStrobeN && !wrStrobeN));

  assert_ack_in_inactive_R7: assert property (@(posedge clk) disable iff (rst)
    reqAck |-> (rdStrobeN && wrStrobeN));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    reqAck |=> !reqAck);

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!rdStrobeN || !wrStrobeN) |-> $stable(modeFlags));

  assert_ack_not_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (!rdStrobeN || !wrStrobeN) |-> !reqAck);

endmodule

bind pataStrobeTimer pataStrobeTimerChecker chk (
  .clk       (clk),
  .rst       (rst),
  .reqAck    (reqAck),
  .rdStrobeN (rdStrobeN),
  .wrStrobeN (wrStrobeN),
  .modeFlags (modeFlags)
);

// File: tb/pataStrobeTimer_test.sv
`timescale 1ns/1ps
module pataStrobeTimer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqCmd = 1'b0;
  logic        reqDev = 1'b0;
  logic [31:0] timingWord0 = '0;
  logic [31:0] timingWord1 = '0;
  logic        reqAck;
  logic        rdStrobeN;
  logic        wrStrobeN;
  logic [3:0]  modeFlags;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pataStrobeTimer uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCmd(reqCmd), .reqDev(reqDev), .timingWord0(timingWord0),
    .timingWord1(timingWord1), .reqAck(reqAck), .rdStrobeN(rdStrobeN),
    .wrStrobeN(wrStrobeN), .modeFlags(modeFlags)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] makeWord(input int v);
    logic [31:0] w;
    int k;
    k = v & 15;
    w = '0;
    w[3:0]   = 4'(15 - k);
    w[7:4]   = 4'(k);
    w[11:8]  = 4'((k * 5) % 16);
    w[15:12] = 4'((k + 3) % 16);
    w[18:16] = 3'(k % 8);
    w[21:19] = 3'(k % 8);
    w[24:22] = 3'(7 - (k % 8));
    w[27:25] = 3'(k);
    w[31:28] = 4'(k);
    return w;
  endfunction

  function automatic int expSetup(input logic [31:0] w, input bit cmd);
    return cmd ? int'(w[24:22]) + 1 : int'(w[21:19]) + 1;
  endfunction
  function automatic int expLow(input logic [31:0] w, input bit cmd);
    return cmd ? int'(w[15:12]) + 1 : int'(w[7:4]) + 1;
  endfunction
  function automatic int expHigh(input logic [31:0] w, input bit cmd);
    return cmd ? int'(w[11:8]) + 1 : int'(w[3:0]) + 1;
  endfunction

  // Called at a falling edge; returns at the falling edge where reqAck is seen.
  task automatic runAccess(input bit dev, input bit cmd, input bit wr, input bit holdReq,
                           input int ePre, input int eLow, input int eHigh, input int eFlags,
                           input string tag);
    int pre = 0;
    int low = 0;
    int high = 0;
    int phase = 0;
    int guard = 0;
    bit wrongSide = 1'b0;
    bit fin = 1'b0;
    bit selLow;
    bit otherLow;
    reqDev = dev; reqCmd = cmd; reqWrite = wr; reqValid = 1'b1;
    while (!fin) begin
      @(negedge clk);
      guard++;
      selLow   = wr ? !wrStrobeN : !rdStrobeN;
      otherLow = wr ? !rdStrobeN : !wrStrobeN;
      if (otherLow) wrongSide = 1'b1;
      case (phase)
        0: if (selLow) begin phase = 1; low = 1; end else pre++;
        1: if (selLow) low++; else begin phase = 2; high = 1; end
        default: if (selLow) wrongSide = 1'b1; else high++;
      endcase
      if (reqAck) fin = 1'b1;
      if (guard > 200) begin
        fin = 1'b1;
        check(1'b0, {tag, " R7 no acknowledge"}, guard, 0);
      end
    end
    if (!holdReq) reqValid = 1'b0;
    check(pre == ePre, {tag, cmd ? " R4 cmd setup" : " R4 data setup"}, pre, ePre);
    check(low == eLow, {tag, cmd ? " R3 cmd active" : " R2 data active"}, low, eLow);
    check(high == eHigh, {tag, cmd ? " R3 cmd inactive R7" : " R2 data inactive R7"}, high, eHigh);
    check(!wrongSide, {tag, " R5 strobe side"}, int'(wrongSide), 0);
    check(int'(modeFlags) == eFlags, {tag, " R11 flags"}, int'(modeFlags), eFlags);
  endtask

  task automatic doFresh(input bit dev, input bit cmd, input bit wr, input string tag);
    logic [31:0] w;
    @(negedge clk);
    check(!reqAck, {tag, " R7 ack one cycle"}, int'(reqAck), 0);
    @(negedge clk);
    w = dev ? timingWord1 : timingWord0;
    runAccess(dev, cmd, wr, 1'b0, expSetup(w, cmd), expLow(w, cmd), expHigh(w, cmd),
              int'(w[31:28]), tag);
  endtask

  initial begin
    logic [31:0] wA;
    logic [31:0] wB;
    repeat (3) @(negedge clk);
    check(rdStrobeN && wrStrobeN, "R1 strobes high in reset", int'({rdStrobeN, wrStrobeN}), 3);
    check(!reqAck && modeFlags == 4'd0, "R1 ack and flags in reset", int'({reqAck, modeFlags}), 0);
    rst = 1'b0;

    // sweep all field values, both devices, directions and access kinds (R2 R3 R4 R5 R6 R11)
    for (int v = 0; v < 16; v++) begin
      timingWord0 = makeWord(v);
      timingWord1 = makeWord(v + 7);
      for (int c = 0; c < 4; c++) begin
        doFresh(c[0] ^ v[0], c[1], c[0], $sformatf("R6 sweep v=%0d c=%0d", v, c));
      end
    end

    // burst: fields from the first word, setup skipped (R8), word changes ignored (R10)
    wA = makeWord(3);
    wB = makeWord(10);
    timingWord0 = wA;
    timingWord1 = wB;
    repeat (2) @(negedge clk);
    runAccess(1'b0, 1'b0, 1'b0, 1'b1, expSetup(wA, 1'b0), expLow(wA, 1'b0), expHigh(wA, 1'b0),
              int'(wA[31:28]), "R8 burst first");
    runAccess(1'b1, 1'b1, 1'b1, 1'b1, 1, expLow(wA, 1'b1), expHigh(wA, 1'b1),
              int'(wA[31:28]), "R8 burst cmd write other dev");
    timingWord0 = wB;
    runAccess(1'b0, 1'b0, 1'b1, 1'b0, 1, expLow(wA, 1'b0), expHigh(wA, 1'b0),
              int'(wA[31:28]), "R10 R8 burst after word change");
    // burst ended by an idle cycle with no request: fresh capture and setup (R9)
    doFresh(1'b0, 1'b1, 1'b0, "R9 after burst");

    // word changed during the setup count of an access (R10)
    wA = makeWord(5);
    timingWord0 = wA;
    repeat (2) @(negedge clk);
    fork
      runAccess(1'b0, 1'b0, 1'b0, 1'b0, expSetup(wA, 1'b0), expLow(wA, 1'b0), expHigh(wA, 1'b0),
                int'(wA[31:28]), "R10 mid access change");
      begin
        repeat (3) @(negedge clk);
        timingWord0 = makeWord(12);
      end
    join

    // reset while a strobe is low (R1)
    wA = makeWord(5);
    timingWord0 = wA;
    repeat (2) @(negedge clk);
    reqDev = 1'b0; reqCmd = 1'b0; reqWrite = 1'b0; reqValid = 1'b1;
    repeat (8) @(negedge clk);
    check(!rdStrobeN, "R2 read strobe low before reset", int'(rdStrobeN), 0);
    rst = 1'b1;
    @(negedge clk);
    check(rdStrobeN && wrStrobeN && !reqAck, "R1 reset mid access", int'({rdStrobeN, wrStrobeN, reqAck}), 6);
    check(modeFlags == 4'd0, "R1 flags cleared", int'(modeFlags), 0);
    reqValid = 1'b0;
    rst = 1'b0;
    doFresh(1'b0, 1'b1, 1'b1, "R1 first access after reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R7 run did not complete actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule